// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits between a host request port and an asynchronous pseudo-static RAM of 256K 16-bit words. The RAM takes all 18 address bits at once, with no multiplexing. Each accepted request becomes one memory cycle. Chip select and the address are presented first. Chip enable is then pulsed low for the access window. A recovery gap with chip enable high follows before the next cycle can begin. Reads drive output enable during the window and capture the data bus on the last window cycle. Writes drive the data bus and the per-byte write strobes during the window.

Every timing figure is set as a nanosecond parameter and turned into a clock-cycle count by rounding up at the configured clock period. The recovery gap is the larger of the precharge minimum and whatever is needed to reach the start-to-start cycle minimum. A refresh scheduler outside the block can claim the memory bus with a single input. While that input is high, no new cycle starts, but a cycle already in progress runs to completion.

Top module: `psram_seq`

## Requirements
- R1: Each access holds `mem_ce_n` low for exactly ceil(T_CE_NS*1000/CLK_PS) consecutive cycles (30 at the defaults). That count never exceeds floor(T_CE_MAX_NS*1000/CLK_PS).
- R2: After `mem_ce_n` rises, it stays high for at least max(ceil(T_PRE_NS), ceil(T_CYC_NS) minus the R1 count) cycles (18 at the defaults). Two successive falling edges of `mem_ce_n` are at least ceil(T_CYC_NS*1000/CLK_PS) cycles apart (48 at the defaults).
- R3: `mem_sel` (active high) is raised, and `mem_addr` shows the request address, at least one cycle before `mem_ce_n` falls. Both stay stable through the whole low window and the recovery gap. `mem_sel` is low when the block is idle.
- R4: For a read (`req_wr`=0), `mem_oe_n` is low in every cycle of the chip-enable window and high otherwise. The data bus is not driven. The data bus value at the last window cycle appears on `rsp_rdata`, with `rsp_valid` high for exactly one cycle.
- R5: For a write (`req_wr`=1), `mem_we_hi_n` is low during the whole window exactly when `req_be[1]` was set, and `mem_we_lo_n` is low exactly when `req_be[0]` was set. When both are used, they fall and rise on the same cycle.
- R6: `mem_dq_oe` is high only during the window of a write with a nonzero byte enable, and `mem_dq_out` then carries the request write data. `mem_oe_n` stays high for writes.
- R7: A write with `req_be`=2'b00 runs a normal chip-enable cycle with no write strobe, no bus drive and no `rsp_valid`.
- R8: While `refresh_owns` is high, `req_ready` is low and no new chip-enable cycle starts. After it drops, a pending request is served normally.
- R9: During and right after reset, `mem_ce_n`, `mem_oe_n`, `mem_we_hi_n` and `mem_we_lo_n` are high. `mem_sel`, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R10: A request is taken only on a cycle with `req_valid` and `req_ready` both high. Each accepted request produces exactly one chip-enable pulse, and `req_ready` stays low from acceptance until the recovery gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| refresh_owns | input | 1 | Refresh scheduler holds the memory bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_sel | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_hi_n | output | 1 | Upper byte write strobe, active low |
| mem_we_lo_n | output | 1 | Lower byte write strobe, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data to the pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable for the data bus |
| mem_dq_in | input | 16 | Data from the pads |

## Verification
The bench builds the block with its default parameters at a 4000 ps clock. This gives a one-cycle setup phase, a 30-cycle window and an 18-cycle gap. At this clock the start-to-start minimum, not the precharge minimum, sets the gap length, so that branch of the gap computation is the one exercised. The bench memory model returns an address-derived pattern only while chip enable and output enable are both low. This lets it check read capture timing, byte-strobe pairing for all four byte-enable codes, and refresh blocking at the pins.

// File: rtl/psram_seq_pkg.sv
`timescale 1ns/1ps
package psram_seq_pkg;

  // Phase of one memory cycle.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // Round a nanosecond minimum up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_rst.sv
`timescale 1ns/1ps
module psram_seq_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/psram_seq_timer.sv
`timescale 1ns/1ps
module psram_seq_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/psram_seq_ctrl.sv
`timescale 1ns/1ps
module psram_seq_ctrl import psram_seq_pkg::*; #(
  parameter  int unsigned SETUP_CYC = 1,
  parameter  int unsigned ACT_CYC   = 30,
  parameter  int unsigned GAP_CYC   = 18,
  localparam int unsigned MAX_LD    = max_u(max_u(SETUP_CYC, ACT_CYC), GAP_CYC),
  localparam int unsigned CNT_W     = $clog2(MAX_LD + 1)
) (
  input  logic   clk,
  input  logic   rst_sn,
  input  logic   req_valid,
  input  logic   refresh_owns,
  output logic   req_ready,
  output logic   accept,
  output phase_e phase,
  output logic   capture
);

  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] ACT_M1   = CNT_W'(ACT_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_M1   = CNT_W'(GAP_CYC - 1);

  phase_e           ph_q, ph_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             t_zero;

  psram_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .load     (ld),
    .load_val (ld_val),
    .zero     (t_zero)
  );

  assign req_ready = (ph_q == PH_IDLE) & ~refresh_owns;
  assign accept    = req_valid & req_ready;
  assign capture   = (ph_q == PH_ACTIVE) & t_zero;
  assign phase     = ph_q;

  always_comb begin
    ph_d   = ph_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d = PH_SETUP; ld = 1'b1; ld_val = SETUP_M1;
      end
      PH_SETUP: if (t_zero) begin
        ph_d = PH_ACTIVE; ld = 1'b1; ld_val = ACT_M1;
      end
      PH_ACTIVE: if (t_zero) begin
        ph_d = PH_RECOVER; ld = 1'b1; ld_val = GAP_M1;
      end
      PH_RECOVER: if (t_zero) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  // R8: refresh ownership keeps the sequencer parked
  assert_no_start_in_refresh_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (ph_q == PH_IDLE && refresh_owns) |=> (ph_q == PH_IDLE));

  // R10: a cycle only leaves idle through an accepted request
  assert_start_needs_accept_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (ph_q == PH_IDLE && !req_valid) |=> (ph_q == PH_IDLE));

  assert_window_exit_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (ph_q == PH_ACTIVE) |=> (ph_q == PH_ACTIVE || ph_q == PH_RECOVER));

endmodule

// File: rtl/psram_seq_io.sv
`timescale 1ns/1ps
module psram_seq_io import psram_seq_pkg::*; #(
  parameter  int unsigned ADDR_W = 18,
  parameter  int unsigned DATA_W = 16,
  localparam int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              accept,
  input  logic              capture,
  input  phase_e            phase,
  input  logic              req_wr,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ce_n,
  output logic              sel,
  output logic              oe_n,
  output logic [LANES-1:0]  we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  logic              wr_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q, rsp_d;
  logic              rd_cap;
  logic              act_w, wr_act_w, rd_act_w;

  // Request latch, loaded on the accepting edge.
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_wr;
      be_q    <= req_be;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign act_w    = (phase == PH_ACTIVE);
  assign wr_act_w = act_w & wr_q;
  assign rd_act_w = act_w & ~wr_q;

  // Pin decode from the registered phase and latched request.
  assign ce_n   = ~act_w;
  assign sel    = (phase != PH_IDLE);
  assign oe_n   = ~rd_act_w;
  assign addr   = addr_q;
  assign dq_out = wdata_q;
  assign dq_oe  = wr_act_w & (|be_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign we_n[l] = ~(wr_act_w & be_q[l]);
  end

  // Read capture at the end of the window.
  assign rd_cap = capture & ~wr_q;
  assign rsp_d  = rd_cap;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     rdata_q <= '0;
    else if (rd_cap) rdata_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rsp_q <= 1'b0;
    else         rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // R5: when both strobes are low they were equal one cycle earlier
  assert_strobes_paired_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (&(~we_n)) |-> ($past(we_n) == '0 || $past(we_n) == '1));

  assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (|(~we_n)) |-> (!ce_n && oe_n));

  assert_drive_only_write_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    dq_oe |-> (oe_n && !ce_n && (|(~we_n))));

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ce_n) |-> (sel && $stable(addr)));

  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq import psram_seq_pkg::*; #(
  parameter  int unsigned CLK_PS      = 4000,
  parameter  int unsigned ADDR_W      = 18,
  parameter  int unsigned DATA_W      = 16,
  parameter  int unsigned T_CYC_NS    = 190,
  parameter  int unsigned T_CE_NS     = 120,
  parameter  int unsigned T_CE_MAX_NS = 10000,
  parameter  int unsigned T_PRE_NS    = 60,
  parameter  int unsigned T_SETUP_NS  = 0,
  localparam int unsigned LANES       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              refresh_owns,
  output logic              mem_ce_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_hi_n,
  output logic              mem_we_lo_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned ACT_CYC    = ns_to_cyc(T_CE_NS, CLK_PS);
  localparam int unsigned PRE_CYC    = ns_to_cyc(T_PRE_NS, CLK_PS);
  localparam int unsigned CYC_CYC    = ns_to_cyc(T_CYC_NS, CLK_PS);
  localparam int unsigned SETUP_RAW  = ns_to_cyc(T_SETUP_NS, CLK_PS);
  localparam int unsigned SETUP_CYC  = max_u(SETUP_RAW, 1);
  localparam int unsigned REST_CYC   = (CYC_CYC > ACT_CYC) ? (CYC_CYC - ACT_CYC) : 0;
  localparam int unsigned GAP_CYC    = max_u(max_u(PRE_CYC, REST_CYC), 1);
  localparam int unsigned CE_MAX_CYC = (T_CE_MAX_NS * 1000) / CLK_PS;
  localparam int unsigned MON_W      = $clog2(CE_MAX_CYC + CYC_CYC + GAP_CYC + 2) + 1;

  logic             rst_sn;
  logic             accept;
  logic             capture;
  phase_e           phase;
  logic [LANES-1:0] we_n;

  psram_seq_rst u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  psram_seq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .ACT_CYC   (ACT_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_sn       (rst_sn),
    .req_valid    (req_valid),
    .refresh_owns (refresh_owns),
    .req_ready    (req_ready),
    .accept       (accept),
    .phase        (phase),
    .capture      (capture)
  );

  psram_seq_io #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_io (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .accept    (accept),
    .capture   (capture),
    .phase     (phase),
    .req_wr    (req_wr),
    .req_be    (req_be),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ce_n      (mem_ce_n),
    .sel       (mem_sel),
    .oe_n      (mem_oe_n),
    .we_n      (we_n),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe),
    .dq_in     (mem_dq_in)
  );

  assign mem_we_hi_n = we_n[LANES-1];
  assign mem_we_lo_n = we_n[0];

  // Pin-level timing monitors feeding the assertions below.
  logic [MON_W-1:0] lo_run_q, lo_run_d;
  logic [MON_W-1:0] hi_run_q, hi_run_d;
  logic [MON_W-1:0] since_q, since_d;
  logic             ce_prev_q, seen_q;
  logic             fell_w;

  assign fell_w = ~mem_ce_n & ce_prev_q;

  always_comb begin
    lo_run_d = mem_ce_n ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
    hi_run_d = mem_ce_n ? ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1) : '0;
    since_d  = fell_w ? MON_W'(1) : ((since_q == '1) ? since_q : since_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lo_run_q  <= '0;
      hi_run_q  <= '0;
      since_q   <= '0;
      ce_prev_q <= 1'b1;
      seen_q    <= 1'b0;
    end else begin
      lo_run_q  <= lo_run_d;
      hi_run_q  <= hi_run_d;
      since_q   <= since_d;
      ce_prev_q <= mem_ce_n;
      seen_q    <= seen_q | ~mem_ce_n;
    end
  end

  assert_ce_width_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(mem_ce_n) |-> (lo_run_q == MON_W'(ACT_CYC) && lo_run_q <= MON_W'(CE_MAX_CYC)));

  assert_ce_gap_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(mem_ce_n) && seen_q) |-> (hi_run_q >= MON_W'(GAP_CYC) && since_q >= MON_W'(CYC_CYC)));

  assert_sel_before_ce_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(mem_ce_n) |-> $past(mem_sel));

endmodule

// File: tb/psram_seq_tb_top.sv
`timescale 1ns/1ps
module psram_seq_tb_top;

  localparam int ACT  = 30;
  localparam int GAP  = 18;
  localparam int SET  = 1;
  localparam int CYCM = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_wr, refresh_owns;
  logic [1:0]  req_be;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_sel, mem_oe_n, mem_we_hi_n, mem_we_lo_n, mem_dq_oe;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] pattern(input logic [17:0] a);
    return 16'h5A3C ^ a[15:0] ^ {14'h0, a[17:16]};
  endfunction

  // Memory model: drives a pattern only while enabled for reading.
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? pattern(mem_addr) : 16'h0BAD;

  psram_seq dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_wr (req_wr),
    .req_be (req_be), .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .refresh_owns (refresh_owns),
    .mem_ce_n (mem_ce_n), .mem_sel (mem_sel), .mem_oe_n (mem_oe_n),
    .mem_we_hi_n (mem_we_hi_n), .mem_we_lo_n (mem_we_lo_n), .mem_addr (mem_addr),
    .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  // {wr, be[1:0], addr[17:0], wdata[15:0]}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 2'b11, 18'h00000, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000},
    {1'b1, 2'b11, 18'h12345, 16'hBEEF},
    {1'b1, 2'b10, 18'h00080, 16'hA1B2},
    {1'b1, 2'b01, 18'h3FF7F, 16'h1357},
    {1'b1, 2'b00, 18'h20001, 16'hFFFF},
    {1'b0, 2'b01, 18'h2AAAA, 16'h0000},
    {1'b1, 2'b11, 18'h15555, 16'h0000}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk("R3", {tag, " sel idle"}, 32'(mem_sel), 32'd0);
    chk("R6", {tag, " bus idle"}, {mem_ce_n, mem_oe_n, mem_we_hi_n, mem_we_lo_n, mem_dq_oe},
        {4'b1111, 1'b0});
  endtask

  task automatic run_access(input logic wr, input logic [1:0] be,
                            input logic [17:0] a, input logic [15:0] d);
    int setup_n = 0, low_n = 0, gap_n = 0, rsp_n = 0;
    int bad_sa = 0, bad_st = 0, bad_dq = 0;
    logic [15:0] rd = '0;
    logic e_oe, e_hi, e_lo, e_drv;
    e_oe  = wr;
    e_hi  = ~(wr & be[1]);
    e_lo  = ~(wr & be[0]);
    e_drv = wr & (|be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_be = be; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 16'h0; req_addr = 18'h0;
    while (!req_ready) begin
      if (mem_sel !== 1'b1 || mem_addr !== a) bad_sa++;
      if (mem_ce_n) begin
        if (low_n == 0) setup_n++; else gap_n++;
        if ({mem_oe_n, mem_we_hi_n, mem_we_lo_n, mem_dq_oe} !== 4'b1110) bad_st++;
      end else begin
        low_n++;
        if (mem_oe_n !== e_oe || mem_we_hi_n !== e_hi || mem_we_lo_n !== e_lo) bad_st++;
        if (mem_dq_oe !== e_drv) bad_dq++;
        if (e_drv && mem_dq_out !== d) bad_dq++;
      end
      if (rsp_valid) begin rsp_n++; rd = rsp_rdata; end
      @(negedge clk);
    end
    chk("R1", "window length", 32'(low_n), 32'(ACT));
    chk("R2", "gap length", 32'(gap_n), 32'(GAP));
    chk("R3", "setup length", 32'(setup_n), 32'(SET));
    chk("R3", "sel/addr held", 32'(bad_sa), 32'd0);
    chk(wr ? "R5" : "R4", "strobe pattern", 32'(bad_st), 32'd0);
    chk("R6", "data drive", 32'(bad_dq), 32'd0);
    if (wr) chk(be == 2'b00 ? "R7" : "R6", "no read strobe", 32'(rsp_n), 32'd0);
    else begin
      chk("R4", "rsp pulse count", 32'(rsp_n), 32'd1);
      chk("R4", "read data", 32'(rd), 32'(pattern(a)));
    end
    chk_idle("after access");
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int acc, falls, t, f0, f1, bad;
    logic prev;
    rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_be = 2'b00;
    req_addr = '0; req_wdata = '0; refresh_owns = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs while reset is asserted
    chk("R9", "pins in reset", {mem_ce_n, mem_sel, mem_oe_n, mem_we_hi_n, mem_we_lo_n, mem_dq_oe, rsp_valid},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "ready after reset", 32'(req_ready), 32'd1);
    chk("R9", "pins after reset", {mem_ce_n, mem_sel, mem_oe_n, mem_we_hi_n, mem_we_lo_n, mem_dq_oe, rsp_valid},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});

    // R10: no valid, no activity
    bad = 0;
    repeat (10) begin @(negedge clk); if (!mem_ce_n || mem_sel) bad++; end
    chk("R10", "idle without valid", 32'(bad), 32'd0);

    // Vector table
    for (int i = 0; i < 8; i++)
      run_access(VEC[i][36], VEC[i][35:34], VEC[i][33:16], VEC[i][15:0]);

    // R8: refresh holds off a pending request
    @(negedge clk);
    refresh_owns = 1'b1; req_valid = 1'b1; req_wr = 1'b0; req_be = 2'b11; req_addr = 18'h01234;
    bad = 0;
    repeat (20) begin @(negedge clk); if (!mem_ce_n || mem_sel || req_ready) bad++; end
    chk("R8", "blocked during refresh", 32'(bad), 32'd0);
    req_valid = 1'b0; refresh_owns = 1'b0;
    run_access(1'b0, 2'b11, 18'h01234, 16'h0);

    // R2/R10: back-to-back requests with valid held
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_be = 2'b11; req_addr = 18'h00F0F;
    acc = req_ready ? 1 : 0; falls = 0; t = 0; f0 = 0; f1 = 0; prev = mem_ce_n;
    repeat (140) begin
      @(negedge clk); t++;
      if (acc == 2) req_valid = 1'b0;
      if (prev && !mem_ce_n) begin
        if (falls == 0) f0 = t; else f1 = t;
        falls++;
      end
      prev = mem_ce_n;
      if (req_valid && req_ready) acc++;
    end
    chk("R10", "pulses for two requests", 32'(falls), 32'd2);
    chk("R2", "start to start >= min", 32'((f1 - f0) >= CYCM), 32'd1);
    chk_idle("after back-to-back");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule